// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block translates a virtual address into a physical page address by reading page-table entries from memory, one entry at a time. A one-cycle start pulse launches a walk. The walker picks a root table base from one of two root registers, chosen by the top bit of the virtual address. It then descends through up to four directory levels and a final page-table level. Each level is described by a bit position and a field width, and both come from configuration inputs.

A level whose width is zero is passed over without a memory access. A directory entry with its huge flag set ends the descent at once and becomes the leaf. Before the leaf is used, a huge leaf is rewritten into the ordinary leaf layout. At the end, a one-cycle done pulse presents the outcome: success or no-match, read and write permission, and the physical address aligned to a page.

Reads go through a request port with a valid/ready handshake and come back on a response-valid strobe. Only one read is outstanding at a time. The configuration inputs must be held stable while a walk runs. The virtual address and the root registers are captured when the walk starts.

Top module: `ptw_walker`

## Requirements
- R1: After synchronous reset, `done_o`, `ok_o`, `rd_ok_o`, `wr_ok_o` and `mem_req_valid_o` are 0 and `pa_o` is 0.
- R2: The starting table base is `root_hi_i` when virtual address bit 63 is 1 and `root_lo_i` otherwise. Only its low `PA_W` bits are kept.
- R3: Directory levels are visited in the order 4, 3, 2, 1. Level k uses slice k-1 of `dir_pos_i` and `dir_wid_i`. A level whose width is 0 issues no read, so the sequence of read addresses holds only the levels with a non-zero width.
- R4: Each read address is `base | (idx << 3)`, where `idx = (va >> pos) & ((1 << wid) - 1)`. Every entry is therefore 8 bytes.
- R5: A loaded directory entry keeps only its low `PA_W` bits before it serves as the next base. No request address has a bit set at or above `PA_W`.
- R6: When a masked directory entry (or the root, if every level was skipped) has bit 6 (huge) set, no further read is made. That entry is the leaf. Its bits 14:13 (level) and bit 6 are cleared. If bit 12 (huge-global) is set, bit 12 is cleared and bit 6 (global) is set.
- R7: If no huge entry is met, exactly one more read is made using `pt_pos_i`/`pt_wid_i`. Its response is used as the leaf without masking.
- R8: If leaf bit 0 (valid) is clear, the walk ends with `ok_o`, `rd_ok_o` and `wr_ok_o` at 0 and `pa_o` at 0.
- R9: On success `ok_o` and `rd_ok_o` are 1, and `wr_ok_o` equals leaf bit 1 (dirty).
- R10: On success, `pa_o` is computed as follows. Take the leaf plus `va & ((1 << p) - 1)`. Here p is the position of the last level handled: the page-table level, the huge level, or level 1 when the root itself is huge. Clear bits 63, 62 and 61, then clear the low `PAGE_SHIFT` bits.
- R11: `mem_req_valid_o` stays high with a stable address until `mem_req_ready_i` is seen. No new request is made before the response arrives.
- R12: `done_o` is a one-cycle pulse per walk. A start pulse while a walk is in progress is ignored: it neither changes that walk's result nor causes another walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a walk (ignored while busy) |
| va_i | input | 64 | Virtual address to translate |
| root_lo_i | input | 64 | Root table base for the lower half |
| root_hi_i | input | 64 | Root table base for the upper half |
| dir_pos_i | input | 4*POS_W | Bit position per directory level, level k in slice k-1 |
| dir_wid_i | input | 4*WID_W | Index width per directory level, level k in slice k-1 |
| pt_pos_i | input | POS_W | Bit position of the page-table level |
| pt_wid_i | input | WID_W | Index width of the page-table level |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | 64 | Read byte address |
| mem_resp_valid_i | input | 1 | Read data valid |
| mem_resp_data_i | input | 64 | Read data |
| done_o | output | 1 | Walk finished (one cycle) |
| ok_o | output | 1 | Translation found |
| rd_ok_o | output | 1 | Read permitted |
| wr_ok_o | output | 1 | Write permitted |
| pa_o | output | 64 | Page-aligned physical address |

## Verification
The main walk is tried with several input patterns, and each one separates a different path. A full four-level table plus the page-table read checks the level order and the index arithmetic. A layout with the top levels at width zero, reached through the upper root, shows that skipped levels make no read and that the upper root is chosen. Huge leaves at level 2 and level 1, with and without the huge-global bit, show the early stop and the rewrite. A configuration with every directory width at zero is run twice: once with a huge root, which makes no read at all, and once with an ordinary root, which makes a single page-table read. Invalid leaves on both the normal and the huge path check the no-match result, and a walk under a stalling ready and a slow response, with a stray start injected, shows the handshake holding and the start being ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ENTRY_W   = 64;
    localparam int NUM_DIR   = 4;
    localparam int LVL_W     = 3;

    // Leaf and directory entry bit layout
    localparam int V_BIT     = 0;
    localparam int D_BIT     = 1;
    localparam int G_BIT     = 6;
    localparam int HUGE_BIT  = 6;
    localparam int HGLOB_BIT = 12;
    localparam int LVL_LO    = 13;
    localparam int LVL_HI    = 14;
    localparam int NR_BIT    = 61;
    localparam int NX_BIT    = 62;
    localparam int RPLV_BIT  = 63;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_REQ,
        ST_WAIT,
        ST_FIN
    } walk_state_e;

    typedef struct packed {
        logic               ok;
        logic               rd;
        logic               wr;
        logic [ENTRY_W-1:0] pa;
    } walk_result_t;

    function automatic logic [ENTRY_W-1:0] low_mask(input logic [5:0] pos);
        return (64'd1 << pos) - 64'd1;
    endfunction

    function automatic logic [ENTRY_W-1:0] level_index(
        input logic [ENTRY_W-1:0] va,
        input logic [5:0]         pos,
        input logic [4:0]         wid
    );
        return (va >> pos) & ((64'd1 << wid) - 64'd1);
    endfunction

endpackage

// File: rtl/ptw_level_sel.sv
module ptw_level_sel
    import ptw_pkg::*;
#(
    parameter int POS_W = 6,
    parameter int WID_W = 5
) (
    input  logic [LVL_W-1:0]         lvl_i,
    input  logic [NUM_DIR*POS_W-1:0] dir_pos_i,
    input  logic [NUM_DIR*WID_W-1:0] dir_wid_i,
    input  logic [POS_W-1:0]         pt_pos_i,
    input  logic [WID_W-1:0]         pt_wid_i,
    output logic [POS_W-1:0]         pos_o,
    output logic [WID_W-1:0]         wid_o
);

    logic [POS_W-1:0] pos_arr [NUM_DIR];
    logic [WID_W-1:0] wid_arr [NUM_DIR];
    logic [LVL_W-1:0] slot;

    for (genvar k = 0; k < NUM_DIR; k++) begin : g_unpack
        assign pos_arr[k] = dir_pos_i[k*POS_W +: POS_W];
        assign wid_arr[k] = dir_wid_i[k*WID_W +: WID_W];
    end

    assign slot = lvl_i - 3'd1;

    always_comb begin
        if (lvl_i == '0) begin
            pos_o = pt_pos_i;
            wid_o = pt_wid_i;
        end else begin
            pos_o = pos_arr[slot[1:0]];
            wid_o = wid_arr[slot[1:0]];
        end
    end

endmodule

// File: rtl/ptw_leaf_fmt.sv
module ptw_leaf_fmt
    import ptw_pkg::*;
#(
    parameter int PAGE_SHIFT = 12
) (
    input  logic [ENTRY_W-1:0] leaf_i,
    input  logic               huge_i,
    input  logic [ENTRY_W-1:0] va_i,
    input  logic [5:0]         last_pos_i,
    output walk_result_t       res_o
);

    localparam logic [ENTRY_W-1:0] PAGE_LOW = (64'd1 << PAGE_SHIFT) - 64'd1;

    logic [ENTRY_W-1:0] norm;
    logic [ENTRY_W-1:0] sum;

    always_comb begin
        norm = leaf_i;
        if (huge_i) begin
            norm[LVL_HI:LVL_LO] = '0;
            norm[HUGE_BIT]      = 1'b0;
            if (norm[HGLOB_BIT]) begin
                norm[HGLOB_BIT] = 1'b0;
                norm[G_BIT]     = 1'b1;
            end
        end
        sum           = norm + (va_i & low_mask(last_pos_i));
        sum[RPLV_BIT] = 1'b0;
        sum[NX_BIT]   = 1'b0;
        sum[NR_BIT]   = 1'b0;
        res_o         = '0;
        if (norm[V_BIT]) begin
            res_o.ok = 1'b1;
            res_o.rd = 1'b1;
            res_o.wr = norm[D_BIT];
            res_o.pa = sum & ~PAGE_LOW;
        end
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int PA_W       = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int POS_W      = 6,
    parameter int WID_W      = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic [63:0]              va_i,
    input  logic [63:0]              root_lo_i,
    input  logic [63:0]              root_hi_i,
    input  logic [NUM_DIR*POS_W-1:0] dir_pos_i,
    input  logic [NUM_DIR*WID_W-1:0] dir_wid_i,
    input  logic [POS_W-1:0]         pt_pos_i,
    input  logic [WID_W-1:0]         pt_wid_i,
    output logic                     mem_req_valid_o,
    input  logic                     mem_req_ready_i,
    output logic [63:0]              mem_req_addr_o,
    input  logic                     mem_resp_valid_i,
    input  logic [63:0]              mem_resp_data_i,
    output logic                     done_o,
    output logic                     ok_o,
    output logic                     rd_ok_o,
    output logic                     wr_ok_o,
    output logic [63:0]              pa_o
);

    localparam logic [ENTRY_W-1:0] PA_MASK = (64'd1 << PA_W) - 64'd1;

    walk_state_e        state_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [ENTRY_W-1:0] va_q;
    logic [ENTRY_W-1:0] base_q;
    logic [ENTRY_W-1:0] leaf_q;
    logic               huge_q;
    logic [POS_W-1:0]   last_pos_q;
    logic [ENTRY_W-1:0] addr_q;
    logic               done_q;
    walk_result_t       res_q;

    logic [POS_W-1:0]   sel_pos;
    logic [WID_W-1:0]   sel_wid;
    logic [ENTRY_W-1:0] idx;
    logic [ENTRY_W-1:0] next_addr;
    logic [ENTRY_W-1:0] resp_masked;
    walk_result_t       fmt_res;

    ptw_level_sel #(.POS_W(POS_W), .WID_W(WID_W)) u_sel (
        .lvl_i     (lvl_q),
        .dir_pos_i (dir_pos_i),
        .dir_wid_i (dir_wid_i),
        .pt_pos_i  (pt_pos_i),
        .pt_wid_i  (pt_wid_i),
        .pos_o     (sel_pos),
        .wid_o     (sel_wid)
    );

    ptw_leaf_fmt #(.PAGE_SHIFT(PAGE_SHIFT)) u_fmt (
        .leaf_i     (leaf_q),
        .huge_i     (huge_q),
        .va_i       (va_q),
        .last_pos_i (last_pos_q),
        .res_o      (fmt_res)
    );

    assign idx         = level_index(va_q, sel_pos, sel_wid);
    assign next_addr   = base_q | (idx << 3);
    assign resp_masked = mem_resp_data_i & PA_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            lvl_q      <= '0;
            va_q       <= '0;
            base_q     <= '0;
            leaf_q     <= '0;
            huge_q     <= 1'b0;
            last_pos_q <= '0;
            addr_q     <= '0;
            done_q     <= 1'b0;
            res_q      <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        va_q    <= va_i;
                        base_q  <= (va_i[63] ? root_hi_i : root_lo_i) & PA_MASK;
                        lvl_q   <= 3'd4;
                        huge_q  <= 1'b0;
                        state_q <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    if (lvl_q != '0) begin
                        last_pos_q <= sel_pos;
                        if (sel_wid == '0) begin
                            lvl_q <= lvl_q - 3'd1;
                        end else begin
                            addr_q  <= next_addr;
                            state_q <= ST_REQ;
                        end
                    end else if (base_q[HUGE_BIT]) begin
                        leaf_q  <= base_q;
                        huge_q  <= 1'b1;
                        state_q <= ST_FIN;
                    end else begin
                        last_pos_q <= sel_pos;
                        addr_q     <= next_addr;
                        state_q    <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready_i) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_resp_valid_i) begin
                        if (lvl_q != '0) begin
                            if (resp_masked[HUGE_BIT]) begin
                                leaf_q  <= resp_masked;
                                huge_q  <= 1'b1;
                                state_q <= ST_FIN;
                            end else begin
                                base_q  <= resp_masked;
                                lvl_q   <= lvl_q - 3'd1;
                                state_q <= ST_STEP;
                            end
                        end else begin
                            leaf_q  <= mem_resp_data_i;
                            huge_q  <= 1'b0;
                            state_q <= ST_FIN;
                        end
                    end
                end
                ST_FIN: begin
                    res_q   <= fmt_res;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req_valid_o = (state_q == ST_REQ);
    assign mem_req_addr_o  = addr_q;
    assign done_o          = done_q;
    assign ok_o            = res_q.ok;
    assign rd_ok_o         = res_q.rd;
    assign wr_ok_o         = res_q.wr;
    assign pa_o            = res_q.pa;

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    assert_no_req_in_wait_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

    assert_addr_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o |-> ((mem_req_addr_o & ~PA_MASK) == '0));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_busy_keeps_va_R12: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start_i) |=> $stable(va_q));

    assert_nomatch_clean_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ok_o) |-> (!rd_ok_o && !wr_ok_o && pa_o == '0));

    assert_read_granted_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && ok_o) |-> rd_ok_o);

    assert_pa_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (pa_o[PAGE_SHIFT-1:0] == '0 && pa_o[63:61] == 3'b000));

endmodule

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;

    localparam int PA_W = 48;
    localparam logic [63:0] PAM = (64'd1 << PA_W) - 64'd1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] va = '0;
    logic [63:0] root_lo = '0;
    logic [63:0] root_hi = '0;
    logic [5:0]  dpos [1:4];
    logic [4:0]  dwid [1:4];
    logic [5:0]  ppos = 6'd12;
    logic [4:0]  pwid = 5'd9;
    logic [23:0] dir_pos;
    logic [19:0] dir_wid;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [63:0] req_addr;
    logic        resp_valid = 1'b0;
    logic [63:0] resp_data = '0;
    logic        done, ok, rd_ok, wr_ok;
    logic [63:0] pa;

    assign dir_pos = {dpos[4], dpos[3], dpos[2], dpos[1]};
    assign dir_wid = {dwid[4], dwid[3], dwid[2], dwid[1]};

    always #2 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst(rst), .start_i(start), .va_i(va),
        .root_lo_i(root_lo), .root_hi_i(root_hi),
        .dir_pos_i(dir_pos), .dir_wid_i(dir_wid),
        .pt_pos_i(ppos), .pt_wid_i(pwid),
        .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready),
        .mem_req_addr_o(req_addr), .mem_resp_valid_i(resp_valid),
        .mem_resp_data_i(resp_data), .done_o(done), .ok_o(ok),
        .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .pa_o(pa)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_q [$];
    logic        exp_ok, exp_rd, exp_wr;
    logic [63:0] exp_pa;
    bit          expect_done = 0;
    bit          got_done = 0;
    int          lat = 0;
    int          rmod = 0;
    int          cyc = 0;
    bit          pend = 0;
    int          cnt = 0;
    logic [63:0] paddr = '0;

    task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic logic [63:0] memrd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // Behavioural reference of a walk
    task automatic model(input logic [63:0] v);
        logic [63:0] cur, a, idx, t;
        int lastpos;
        bit huge;
        exp_q.delete();
        cur = (v[63] ? root_hi : root_lo) & PAM;
        lastpos = 0;
        huge = 0;
        for (int l = 4; l >= 1; l--) begin
            lastpos = int'(dpos[l]);
            if (dwid[l] == 0) continue;
            idx = (v >> dpos[l]) & ((64'd1 << dwid[l]) - 1);
            a = cur | (idx << 3);
            exp_q.push_back(a);
            cur = memrd(a) & PAM;
            if (cur[6]) begin huge = 1; break; end
        end
        if (cur[6]) huge = 1;
        if (huge) begin
            cur[14:13] = 2'b00;
            cur[6] = 1'b0;
            if (cur[12]) begin cur[12] = 1'b0; cur[6] = 1'b1; end
        end else begin
            lastpos = int'(ppos);
            idx = (v >> ppos) & ((64'd1 << pwid) - 1);
            a = cur | (idx << 3);
            exp_q.push_back(a);
            cur = memrd(a);
        end
        if (!cur[0]) begin
            exp_ok = 0; exp_rd = 0; exp_wr = 0; exp_pa = 0;
        end else begin
            exp_ok = 1; exp_rd = 1; exp_wr = cur[1];
            t = cur + (v & ((64'd1 << lastpos) - 1));
            t[63:61] = 3'b000;
            exp_pa = t & ~64'hFFF;
        end
    endtask

    // Stimulus: build tables so the walk for v reaches leaf (huge at hl, 0 = page-table leaf)
    task automatic build(input logic [63:0] v, input logic [63:0] leaf, input int hl, input int id);
        logic [63:0] cur, a, idx, nxt;
        mem.delete();
        cur = (v[63] ? root_hi : root_lo) & PAM;
        for (int l = 4; l >= 1; l--) begin
            if (dwid[l] == 0) continue;
            idx = (v >> dpos[l]) & ((64'd1 << dwid[l]) - 1);
            a = cur | (idx << 3);
            if (l == hl) begin mem[a] = leaf; return; end
            nxt = 64'h0000_0100_0000 * 64'(id + 1) + 64'(l) * 64'h1000;
            mem[a] = nxt | 64'hFF00_0000_0000_0000;
            cur = nxt;
        end
        idx = (v >> ppos) & ((64'd1 << pwid) - 1);
        mem[cur | (idx << 3)] = leaf;
    endtask

    // Memory responder and per-clock comparison
    always @(negedge clk) begin
        cyc++;
        resp_valid = 1'b0;
        req_ready = (rmod == 0) ? 1'b1 : ((cyc % rmod) == 0);
        if (!rst) begin
            if (pend) begin
                if (cnt == 0) begin
                    resp_valid = 1'b1;
                    resp_data = memrd(paddr);
                    pend = 0;
                end else cnt--;
            end else if (req_valid && req_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3 unexpected read", req_addr, 64'd0);
                end else begin
                    chk(req_addr == exp_q[0], "R3 R4 read address", req_addr, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                paddr = req_addr;
                pend = 1;
                cnt = lat;
            end
            if (done) begin
                if (!expect_done) begin
                    chk(0, "R12 unexpected done", 64'(done), 64'd0);
                end else begin
                    chk(ok == exp_ok, "R8 R9 ok", 64'(ok), 64'(exp_ok));
                    chk(rd_ok == exp_rd, "R9 read", 64'(rd_ok), 64'(exp_rd));
                    chk(wr_ok == exp_wr, "R9 write", 64'(wr_ok), 64'(exp_wr));
                    chk(pa == exp_pa, "R6 R10 pa", pa, exp_pa);
                    got_done = 1;
                    expect_done = 0;
                end
            end
        end
    end

    task automatic run_walk(input logic [63:0] v, input bit inject, input string tag);
        int guard;
        model(v);
        got_done = 0;
        expect_done = 1;
        @(negedge clk);
        va = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            repeat (2) @(negedge clk);
            va = ~v; start = 1'b1;
            @(negedge clk);
            start = 1'b0; va = v;
        end
        guard = 0;
        while (!got_done && guard < 3000) begin @(negedge clk); guard++; end
        chk(got_done, {tag, " walk completes"}, 64'(got_done), 64'd1);
        chk(exp_q.size() == 0, {tag, " R3 R7 read count"}, 64'(exp_q.size()), 64'd0);
        expect_done = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cfg_full();
        dpos[4] = 6'd48; dwid[4] = 5'd6;
        dpos[3] = 6'd39; dwid[3] = 5'd9;
        dpos[2] = 6'd30; dwid[2] = 5'd9;
        dpos[1] = 6'd21; dwid[1] = 5'd9;
        ppos = 6'd12; pwid = 5'd9;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        logic [63:0] v, leaf;
        cfg_full();
        root_lo = 64'h0000_0000_0001_0000;
        root_hi = 64'hABCD_0000_0020_0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!done && !req_valid, "R1 done/req after reset", {62'd0, done, req_valid}, 64'd0);
        chk(!ok && !rd_ok && !wr_ok && pa == 0, "R1 result after reset", pa, 64'd0);

        // R3 R4 R5 R7 R9 R10: full four-level walk, low root, dirty leaf with top flags
        v = 64'h0012_3456_789A_BCDE;
        leaf = 64'hE000_0000_0ABC_D033;
        build(v, leaf, 0, 0);
        run_walk(v, 0, "R7 full walk");

        // R2 R3: upper root with garbage above PA_W, top two levels skipped, clean leaf
        dwid[4] = 5'd0; dwid[3] = 5'd0;
        v = 64'hFFFF_FFFF_C123_4567;
        leaf = 64'h0000_0000_0055_5001;
        build(v, leaf, 0, 1);
        run_walk(v, 0, "R2 upper root skip");

        // R6: huge leaf at level 2 with huge-global and level bits
        cfg_full();
        v = 64'h0000_0012_3456_789A;
        leaf = 64'h0000_0040_0000_7043;
        build(v, leaf, 2, 2);
        run_walk(v, 0, "R6 huge level2 hglobal");

        // R6: huge leaf at level 1 without huge-global, read-only
        v = 64'h0000_0001_0ABC_DEF0;
        leaf = 64'h4000_0000_0060_6041;
        build(v, leaf, 1, 3);
        run_walk(v, 0, "R6 huge level1");

        // R8: invalid ordinary leaf
        v = 64'h0000_0000_1234_5000;
        leaf = 64'h0000_0000_0077_7002;
        build(v, leaf, 0, 4);
        run_walk(v, 0, "R8 invalid leaf");

        // R8: invalid huge leaf
        leaf = 64'h0000_0000_4000_1042;
        build(v, leaf, 2, 5);
        run_walk(v, 0, "R8 invalid huge");

        // R6 R3: all directory widths zero, huge root, no reads
        dwid[4] = 0; dwid[3] = 0; dwid[2] = 0; dwid[1] = 0;
        root_lo = 64'hFF00_0000_0420_1043;
        mem.delete();
        v = 64'h0000_0000_0012_3456;
        run_walk(v, 0, "R6 huge root");

        // R7: all directory widths zero, ordinary root, one page-table read
        root_lo = 64'h0000_0000_0003_0000;
        v = 64'h0000_0000_0012_3456;
        leaf = 64'h0000_0000_0099_9003;
        build(v, leaf, 0, 6);
        run_walk(v, 0, "R7 root only");

        // R11 R12: stalling ready, slow response, stray start while busy
        cfg_full();
        root_lo = 64'h0000_0000_0001_0000;
        lat = 3; rmod = 3;
        v = 64'h0000_2222_3333_4444;
        leaf = 64'h0000_0000_0123_4003;
        build(v, leaf, 0, 7);
        run_walk(v, 1, "R11 R12 stall and stray start");
        repeat (20) @(negedge clk);
        chk(!req_valid && !done, "R12 no extra walk", {62'd0, done, req_valid}, 64'd0);
        lat = 0; rmod = 0;

        finish_run();
    end

endmodule